// File: doc/BRIEF.md
# Cascadable Column Enable Token Chain

This block steps a single enable token through a row of stages inside one column-driver chip. Each stage selects one group of three adjacent output channels for loading. A one-clock enable pulse enters on one of two cascade pins and moves one stage per rising clock edge. When the token leaves the last stage it is handed to the next chip in the chain on the other cascade pin. The block then turns off its internal shift enable, so the stage flops stop toggling until a new token arrives.

A direction input chooses which cascade pin receives the token and which drives the outgoing pulse. It also chooses whether the token walks from channel group 0 upward or from the top group downward. Each bidirectional pin is modelled as a separate input, output and output-enable. A high latch strobe and a low clear input both empty the chain and close the shift enable. Both act on the clock edge.

Top module: `enable_token_chain`

## Requirements
- R1: With `dir` high, a pulse on `casc_a_in` sampled at a rising edge sets `stage_en[0]`, and each later edge moves it from `stage_en[i]` to `stage_en[i+1]`.
- R2: With `dir` low, the token enters on `casc_b_in`, first sets `stage_en[STAGES-1]`, and moves from `stage_en[i]` to `stage_en[i-1]` on each edge.
- R3: With `dir` high, `casc_a_oe` is 0 and `casc_b_oe` is 1. With `dir` low, `casc_a_oe` is 1 and `casc_b_oe` is 0. The output of the pin that is not enabled is held at 0.
- R4: The enabled cascade output is high for exactly the cycle in which the last stage in walk order holds the token. That stage is `stage_en[STAGES-1]` for `dir` high and `stage_en[0]` for `dir` low. One edge later the chain no longer holds that token.
- R5: After STAGES shifts counted from the token that started the window, the shift enable closes. Any second token that entered during the window then stays frozen in its stage.
- R6: A pulse on the cascade pin that is currently the output has no effect. A token sampled while the chain is idle reopens the shift enable, and any frozen token moves on again.
- R7: A high `strobe` at a rising edge clears every stage and closes the shift enable. This takes priority over a token arriving at the same edge.
- R8: A low `clear_n` at a rising edge clears every stage and closes the shift enable. While it is low, all stage enables and both cascade outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| clear_n | input | 1 | Synchronous active-low clear |
| strobe | input | 1 | Latch strobe; clears chain and shift enable |
| dir | input | 1 | Walk direction: 1 = upward from group 0, 0 = downward |
| casc_a_in | input | 1 | Cascade pin A input (token input when dir = 1) |
| casc_a_out | output | 1 | Cascade pin A output value |
| casc_a_oe | output | 1 | Cascade pin A output enable |
| casc_b_in | input | 1 | Cascade pin B input (token input when dir = 0) |
| casc_b_out | output | 1 | Cascade pin B output value |
| casc_b_oe | output | 1 | Cascade pin B output enable |
| stage_en | output | STAGES | One enable per group of three channels |

## Verification
The hardest state to reach from the ports is a token frozen in the middle of the chain after the shift enable has closed. A single token always drains completely, so a frozen token never shows up in ordinary operation. The stimulus therefore injects a second pulse eleven edges after the first. When the window of the first token closes, the second token is stranded at stage 53. The bench checks that it stays there over idle cycles, and that a third pulse restarts the chain and moves it to stage 54.

// File: rtl/token_chain_pkg.sv
package token_chain_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } chain_dir_e;

    typedef struct packed {
        logic oe;
        logic drive;
    } pin_drv_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/chain_gate_ctrl.sv
module chain_gate_ctrl
    import token_chain_pkg::*;
#(
    parameter int unsigned STAGES = 64
) (
    input  logic clk,
    input  logic flush,
    input  logic tok_in,
    output logic run,
    output logic shift_en
);
    localparam int unsigned CW = cnt_width(STAGES);
    localparam logic [CW-1:0] LAST = CW'(STAGES - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (flush) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q && tok_in) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign run      = run_q;
    assign shift_en = run_q | tok_in;

endmodule

// File: rtl/token_shift_reg.sv
module token_shift_reg #(
    parameter int unsigned STAGES = 64
) (
    input  logic              clk,
    input  logic              flush,
    input  logic              shift_en,
    input  logic              tok_in,
    output logic [STAGES-1:0] tokens
);
    logic [STAGES-1:0] q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic d;
        if (i == 0) begin : g_head
            assign d = tok_in;
        end else begin : g_body
            assign d = q[i-1];
        end
        always_ff @(posedge clk) begin
            if (flush)         q[i] <= 1'b0;
            else if (shift_en) q[i] <= d;
        end
    end

    assign tokens = q;

endmodule

// File: rtl/cascade_port_mux.sv
module cascade_port_mux
    import token_chain_pkg::*;
#(
    parameter int unsigned STAGES = 64
) (
    input  logic              dir,
    input  logic              a_in,
    input  logic              b_in,
    input  logic [STAGES-1:0] tokens,
    output logic              tok_in,
    output logic              a_out,
    output logic              a_oe,
    output logic              b_out,
    output logic              b_oe,
    output logic [STAGES-1:0] stage_en
);
    chain_dir_e d;
    pin_drv_t   pa, pb;
    logic       tail;

    assign d    = chain_dir_e'(dir);
    assign tail = tokens[STAGES-1];

    always_comb begin
        pa = '{oe: 1'b0, drive: 1'b0};
        pb = '{oe: 1'b0, drive: 1'b0};
        unique case (d)
            DIR_UP: begin
                tok_in = a_in;
                pb     = '{oe: 1'b1, drive: tail};
            end
            default: begin
                tok_in = b_in;
                pa     = '{oe: 1'b1, drive: tail};
            end
        endcase
    end

    assign a_out = pa.drive;
    assign a_oe  = pa.oe;
    assign b_out = pb.drive;
    assign b_oe  = pb.oe;

    for (genvar i = 0; i < STAGES; i++) begin : g_map
        assign stage_en[i] = (d == DIR_UP) ? tokens[i] : tokens[STAGES-1-i];
    end

endmodule

// File: rtl/enable_token_chain.sv
module enable_token_chain
    import token_chain_pkg::*;
#(
    parameter int unsigned STAGES = 64
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              strobe,
    input  logic              dir,
    input  logic              casc_a_in,
    output logic              casc_a_out,
    output logic              casc_a_oe,
    input  logic              casc_b_in,
    output logic              casc_b_out,
    output logic              casc_b_oe,
    output logic [STAGES-1:0] stage_en
);
    logic              flush;
    logic              tok_in;
    logic              run_q;
    logic              shift_en;
    logic [STAGES-1:0] tokens;

    assign flush = strobe | ~clear_n;

    chain_gate_ctrl #(.STAGES(STAGES)) u_gate (
        .clk      (clk),
        .flush    (flush),
        .tok_in   (tok_in),
        .run      (run_q),
        .shift_en (shift_en)
    );

    token_shift_reg #(.STAGES(STAGES)) u_shift (
        .clk      (clk),
        .flush    (flush),
        .shift_en (shift_en),
        .tok_in   (tok_in),
        .tokens   (tokens)
    );

    cascade_port_mux #(.STAGES(STAGES)) u_pins (
        .dir      (dir),
        .a_in     (casc_a_in),
        .b_in     (casc_b_in),
        .tokens   (tokens),
        .tok_in   (tok_in),
        .a_out    (casc_a_out),
        .a_oe     (casc_a_oe),
        .b_out    (casc_b_out),
        .b_oe     (casc_b_oe),
        .stage_en (stage_en)
    );

endmodule

// File: rtl/token_chain_checker.sv
module token_chain_checker #(
    parameter int unsigned STAGES = 64
) (
    input logic              clk,
    input logic              clear_n,
    input logic              strobe,
    input logic              dir,
    input logic              casc_a_in,
    input logic              casc_b_in,
    input logic              casc_a_out,
    input logic              casc_a_oe,
    input logic              casc_b_out,
    input logic              casc_b_oe,
    input logic              run,
    input logic [STAGES-1:0] stage_en
);
    logic active_in;
    assign active_in = dir ? casc_a_in : casc_b_in;

    AST_UP_ADVANCE: assert property (@(posedge clk) disable iff (!clear_n)
        (!strobe && dir && run) |=> (!dir || stage_en[STAGES-1:1] == $past(stage_en[STAGES-2:0]))); // R1

    AST_DOWN_ADVANCE: assert property (@(posedge clk) disable iff (!clear_n)
        (!strobe && !dir && run) |=> (dir || stage_en[STAGES-2:0] == $past(stage_en[STAGES-1:1]))); // R2

    AST_PIN_ROLES: assert property (@(posedge clk)
        dir |-> (!casc_a_oe && casc_b_oe && !casc_a_out)); // R3

    AST_CASCADE_TAIL: assert property (@(posedge clk)
        (dir && casc_b_out) |-> stage_en[STAGES-1]); // R4

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!clear_n)
        (!strobe && !run && !active_in) |=> (!$stable(dir) || $stable(stage_en))); // R5

    AST_START_RUN: assert property (@(posedge clk) disable iff (!clear_n)
        (!strobe && !run && active_in) |=> run); // R6

    AST_STROBE_CLEARS: assert property (@(posedge clk)
        strobe |=> (stage_en == '0 && !run)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk)
        !clear_n |=> (stage_en == '0 && !run)); // R8

endmodule

bind enable_token_chain token_chain_checker #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .clear_n    (clear_n),
    .strobe     (strobe),
    .dir        (dir),
    .casc_a_in  (casc_a_in),
    .casc_b_in  (casc_b_in),
    .casc_a_out (casc_a_out),
    .casc_a_oe  (casc_a_oe),
    .casc_b_out (casc_b_out),
    .casc_b_oe  (casc_b_oe),
    .run        (run_q),
    .stage_en   (stage_en)
);

// File: tb/test_enable_token_chain.sv
module test_enable_token_chain;

    localparam int unsigned N = 64;
    localparam logic [7:0] NONE = 8'd255;

    typedef struct packed {
        logic       dir;
        logic       pin_b;
        logic [7:0] wait_n;
        logic [7:0] exp_idx;
        logic       exp_casc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'd0,  8'd0,  1'b0},
        '{1'b1, 1'b0, 8'd5,  8'd5,  1'b0},
        '{1'b1, 1'b0, 8'd62, 8'd62, 1'b0},
        '{1'b1, 1'b0, 8'd63, 8'd63, 1'b1},
        '{1'b1, 1'b0, 8'd64, NONE,  1'b0},
        '{1'b0, 1'b1, 8'd0,  8'd63, 1'b0},
        '{1'b0, 1'b1, 8'd10, 8'd53, 1'b0},
        '{1'b0, 1'b1, 8'd63, 8'd0,  1'b1},
        '{1'b0, 1'b1, 8'd64, NONE,  1'b0},
        '{1'b1, 1'b1, 8'd3,  NONE,  1'b0},
        '{1'b0, 1'b0, 8'd3,  NONE,  1'b0}
    };

    logic         clk = 1'b0;
    logic         clear_n, strobe, dir, a_in, b_in;
    logic         a_out, a_oe, b_out, b_oe;
    logic [N-1:0] stage_en;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    enable_token_chain #(.STAGES(N)) i_enable_token_chain (
        .clk        (clk),
        .clear_n    (clear_n),
        .strobe     (strobe),
        .dir        (dir),
        .casc_a_in  (a_in),
        .casc_a_out (a_out),
        .casc_a_oe  (a_oe),
        .casc_b_in  (b_in),
        .casc_b_out (b_out),
        .casc_b_oe  (b_oe),
        .stage_en   (stage_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic inject(input logic on_b);
        if (on_b) b_in = 1'b1; else a_in = 1'b1;
        @(negedge clk);
        a_in = 1'b0;
        b_in = 1'b0;
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    function automatic logic [N-1:0] bit_at(input logic [7:0] idx);
        return (idx == NONE) ? '0 : (N'(1) << idx);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_n = 1'b0; strobe = 1'b0; dir = 1'b1; a_in = 1'b0; b_in = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "stage_en after clear", stage_en, '0);
        chk("R8", "cascade outs after clear", N'({a_out, b_out}), '0);
        clear_n = 1'b1;
        @(negedge clk);
        // R3: pin roles
        chk("R3", "oe dir=1", N'({a_oe, b_oe}), N'(2'b01));
        dir = 1'b0;
        @(negedge clk);
        chk("R3", "oe dir=0", N'({a_oe, b_oe}), N'(2'b10));

        // table walk: R1 R2 R4 R6
        for (int v = 0; v < NV; v++) begin
            pulse_strobe();
            dir = VECS[v].dir;
            @(negedge clk);
            inject(VECS[v].pin_b);
            repeat (int'(VECS[v].wait_n)) @(negedge clk);
            chk(VECS[v].dir ? "R1" : "R2", $sformatf("vec %0d stage_en", v),
                stage_en, bit_at(VECS[v].exp_idx));
            chk("R4", $sformatf("vec %0d cascade", v),
                N'(VECS[v].dir ? b_out : a_out), N'(VECS[v].exp_casc));
            chk("R3", $sformatf("vec %0d idle pin out", v),
                N'(VECS[v].dir ? a_out : b_out), '0);
        end

        // R5: second token is frozen after window closes
        pulse_strobe();
        dir = 1'b1;
        @(negedge clk);
        inject(1'b0);
        repeat (10) @(negedge clk);
        inject(1'b0);
        repeat (53) @(negedge clk);
        chk("R5", "second token at window close", stage_en, bit_at(8'd53));
        repeat (5) @(negedge clk);
        chk("R5", "token frozen while idle", stage_en, bit_at(8'd53));
        chk("R5", "no cascade while frozen", N'(b_out), '0);
        // R6: wrong pin has no effect, then restart moves frozen token
        inject(1'b1);
        chk("R6", "pulse on output pin ignored", stage_en, bit_at(8'd53));
        inject(1'b0);
        chk("R6", "restart resumes frozen token", stage_en, bit_at(8'd54) | bit_at(8'd0));

        // R7: strobe beats simultaneous token, then chain stays empty
        strobe = 1'b1;
        a_in = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        a_in = 1'b0;
        chk("R7", "strobe with token", stage_en, '0);
        repeat (3) @(negedge clk);
        chk("R7", "empty after strobe", stage_en, '0);

        // R8: clear during a run
        inject(1'b0);
        repeat (4) @(negedge clk);
        chk("R1", "running before clear", stage_en, bit_at(8'd4));
        clear_n = 1'b0;
        @(negedge clk);
        clear_n = 1'b1;
        chk("R8", "clear mid-run", stage_en, '0);
        repeat (2) @(negedge clk);
        chk("R8", "still empty after clear", stage_en, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule